// File: doc/BRIEF.md
# Comparator-Tracking ADC with Exponential Capacitor Model

This block is the digital half of a low-cost analog-to-digital converter. The only analog parts are a differential input comparator and an external resistor-capacitor network. The comparator reports whether the analog input lies above the voltage on the capacitor. The block answers with a one-bit drive pin that charges the capacitor toward full scale or discharges it toward ground. The capacitor voltage therefore follows the input with a small ripple.

The converted value does not come from counting how long the drive pin is high. The block keeps a fixed-point model of the capacitor voltage and updates it every clock with the exponential charge step of an RC network. That step is a right shift, or the sum of two right shifts. The model therefore tracks the nonlinear charging that occurs near the supply rails. A boxcar averager then smooths and decimates the model into output samples, each marked by a one-cycle valid strobe. The averager always follows the model and never precedes it.

With the default settings the window is 4096 clocks, which gives about 24 kHz output samples from a 100 MHz clock.

Top module: `rcadc_track`

## Requirements
- R1: While `rst` is high at a rising clock edge, the drive pin, the model value, the sample output and the valid strobe all become 0, whatever `cmp_in` does.
- R2: `cmp_in` passes through SYNC_STAGES (default 2) flip-flops and one output register. `drive_out` therefore equals the value `cmp_in` had SYNC_STAGES+1 rising edges earlier. A value of 1 means the input is above the reference and drives the capacitor up.
- R3: When `drive_out` is 1 before an edge, the internal accumulator `a` (WIDTH+G bits, full scale F = 2^(WIDTH+G)) becomes a + floor((F−a)/2^SHIFT) + floor((F−a)/2^SHIFT2). The second term is present only when SHIFT2 is nonzero.
- R4: When `drive_out` is 0 before an edge, the accumulator becomes a − floor(a/2^SHIFT) − floor(a/2^SHIFT2).
- R5: The model never wraps. Holding the drive high settles `model_out` at all ones and keeps it there. Holding the drive low settles it at 0. The model never falls while the drive is high and never rises while it is low.
- R6: `model_out` is the top WIDTH bits of the accumulator. G = max(SHIFT, SHIFT2) guard bits sit below it, so steps smaller than one output LSB still accumulate. From reset, the first upward step gives `model_out` = (F/2^SHIFT + F/2^SHIFT2) >> G, which is 160 with the defaults.
- R7: `sample_valid` is high for exactly one cycle in every 2^DEC cycles. The first pulse comes 2^DEC edges after reset is released.
- R8: At each pulse, `sample_out` equals floor(sum of the 2^DEC `model_out` values of that window / 2^DEC). Between pulses it holds its value.
- R9: With the comparator closed around a constant input code between one quarter and three quarters of full scale, each settled sample lies within FS/8 (512 codes) of that input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_in | input | 1 | Comparator output, asynchronous; 1 = input above reference |
| drive_out | output | 1 | Registered drive to the RC network; 1 = charge |
| model_out | output | WIDTH | Modelled capacitor voltage, unsigned fraction of full scale |
| sample_out | output | WIDTH | Averaged, decimated conversion result |
| sample_valid | output | 1 | One-cycle strobe marking a new `sample_out` |

## Verification
A change on `cmp_in` reaches `drive_out` three rising edges later. The accumulator moves one edge after the drive level it uses. A sample and its strobe appear one edge after the last model value of their window. The bench holds its own copy of the synchronizer, accumulator and window state, worked out from the requirements. It advances that copy by one edge for each edge the design sees, and it compares every output at the following falling edge. The closed-loop checks feed the comparator from the bench's own predicted model. They judge only the samples that follow the first three windows, so the start-up transient is excluded.

// File: rtl/rcadc_pkg.sv
package rcadc_pkg;

  typedef logic [63:0] wide_t;

  typedef enum logic {
    DRV_LOW  = 1'b0,
    DRV_HIGH = 1'b1
  } drive_e;

  // One exponential step toward full scale (up) or zero (down).
  // fbits: total fraction bits; s1/s2: shift amounts, s2 == 0 disables it.
  function automatic wide_t rc_step(wide_t acc, drive_e dir,
                                    int unsigned fbits,
                                    int unsigned s1, int unsigned s2);
    wide_t fs;
    wide_t gap;
    wide_t delta;
    fs    = wide_t'(1) << fbits;
    gap   = (dir == DRV_HIGH) ? (fs - acc) : acc;
    delta = gap >> s1;
    if (s2 != 0) delta = delta + (gap >> s2);
    return (dir == DRV_HIGH) ? (acc + delta) : (acc - delta);
  endfunction

  function automatic int unsigned guard_bits(int unsigned s1, int unsigned s2);
    return (s2 > s1) ? s2 : s1;
  endfunction

endpackage

// File: rtl/rcadc_sync.sv
module rcadc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rcadc_model.sv
module rcadc_model
  import rcadc_pkg::*;
#(
  parameter int WIDTH  = 12,
  parameter int SHIFT  = 5,
  parameter int SHIFT2 = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_i,
  output logic             drive_o,
  output logic [WIDTH-1:0] model_o
);

  localparam int unsigned GUARD = guard_bits(SHIFT, SHIFT2);
  localparam int unsigned AW    = WIDTH + GUARD;

  drive_e          drive_q;
  logic [AW-1:0]   acc_q;
  logic [AW-1:0]   acc_d;
  logic            step_up;     // named event: this edge charges
  logic            model_full;  // named event: model at all ones

  assign step_up    = (drive_q == DRV_HIGH);
  assign model_full = &model_o;

  always_comb begin
    acc_d = AW'(rc_step(wide_t'(acc_q), drive_q, AW, SHIFT, SHIFT2));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q <= DRV_LOW;
      acc_q   <= '0;
    end else begin
      drive_q <= cmp_i ? DRV_HIGH : DRV_LOW;
      acc_q   <= acc_d;
    end
  end

  assign drive_o = (drive_q == DRV_HIGH);
  assign model_o = acc_q[AW-1:GUARD];

  // R3
  acc_rise_chk: assert property (@(posedge clk) disable iff (rst)
    step_up |=> (acc_q >= $past(acc_q)));

  // R4
  acc_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !step_up |=> (acc_q <= $past(acc_q)));

  // R5
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (model_full && step_up) |=> model_full);

endmodule

// File: rtl/rcadc_avg.sv
module rcadc_avg #(
  parameter int WIDTH = 12,
  parameter int DEC   = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] val_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] sample_o
);

  localparam int SW = WIDTH + DEC;

  logic [DEC-1:0]   cnt_q;
  logic [SW-1:0]    sum_q;
  logic [SW-1:0]    total;
  logic             win_end;   // named event: last clock of the window
  logic             valid_q;
  logic [WIDTH-1:0] sample_q;

  assign win_end = &cnt_q;
  assign total   = sum_q + SW'(val_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      sum_q    <= '0;
      valid_q  <= 1'b0;
      sample_q <= '0;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
      valid_q <= win_end;
      if (win_end) begin
        sum_q    <= '0;
        sample_q <= total[SW-1:DEC];
      end else begin
        sum_q    <= total;
      end
    end
  end

  assign valid_o  = valid_q;
  assign sample_o = sample_q;

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q);

  // R8
  sample_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_q |-> $stable(sample_q));

endmodule

// File: rtl/rcadc_track.sv
module rcadc_track #(
  parameter int WIDTH       = 12,
  parameter int SHIFT       = 5,
  parameter int SHIFT2      = 7,
  parameter int DEC         = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_in,
  output logic             drive_out,
  output logic [WIDTH-1:0] model_out,
  output logic [WIDTH-1:0] sample_out,
  output logic             sample_valid
);

  logic cmp_sync;

  rcadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (cmp_in),
    .q_o (cmp_sync)
  );

  rcadc_model #(.WIDTH(WIDTH), .SHIFT(SHIFT), .SHIFT2(SHIFT2)) u_model (
    .clk     (clk),
    .rst     (rst),
    .cmp_i   (cmp_sync),
    .drive_o (drive_out),
    .model_o (model_out)
  );

  rcadc_avg #(.WIDTH(WIDTH), .DEC(DEC)) u_avg (
    .clk      (clk),
    .rst      (rst),
    .val_i    (model_out),
    .valid_o  (sample_valid),
    .sample_o (sample_out)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!drive_out && model_out == '0 && !sample_valid));

endmodule

// File: tb/rcadc_track_test.sv
module rcadc_track_test;

  localparam int W  = 12;
  localparam int S1 = 5;
  localparam int S2 = 7;
  localparam int D  = 12;
  localparam int G  = (S2 > S1) ? S2 : S1;
  localparam longint unsigned FS = 64'd1 << (W + G);
  localparam longint unsigned WIN = 64'd1 << D;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmp_in = 1'b0;
  logic drive_out, sample_valid;
  logic [W-1:0] model_out, sample_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench prediction state
  bit e_s1, e_s2, e_drv, e_valid;
  longint unsigned e_acc, e_sum, e_cnt, e_sample;
  int settle_cnt;

  always #5 clk = ~clk;

  rcadc_track #(.WIDTH(W), .SHIFT(S1), .SHIFT2(S2), .DEC(D), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .cmp_in(cmp_in), .drive_out(drive_out),
    .model_out(model_out), .sample_out(sample_out), .sample_valid(sample_valid)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint unsigned next_acc(longint unsigned a, bit up);
    longint unsigned room;
    room = up ? (FS - a) : a;
    if (up) return a + room / (64'd1 << S1) + room / (64'd1 << S2);
    return a - room / (64'd1 << S1) - room / (64'd1 << S2);
  endfunction

  function automatic longint unsigned e_model();
    return e_acc / (64'd1 << G);
  endfunction

  task automatic zero_model();
    e_s1 = 0; e_s2 = 0; e_drv = 0; e_valid = 0;
    e_acc = 0; e_sum = 0; e_cnt = 0; e_sample = 0;
  endtask

  // Drive cmp for the next edge, predict that edge, check at the negedge.
  task automatic tick(input bit c);
    bit was_up;
    cmp_in = c;
    was_up = e_drv;
    if (e_cnt == WIN - 1) begin
      e_sample = (e_sum + e_model()) / WIN;
      e_valid  = 1;
      e_sum    = 0;
      e_cnt    = 0;
    end else begin
      e_valid = 0;
      e_sum   = e_sum + e_model();
      e_cnt   = e_cnt + 1;
    end
    e_acc = next_acc(e_acc, e_drv);
    e_drv = e_s2;
    e_s2  = e_s1;
    e_s1  = c;
    @(negedge clk);
    chk("R2 drive", drive_out, e_drv);
    chk(was_up ? "R3 model up" : "R4 model down", model_out, e_model());
    chk("R7 valid", sample_valid, e_valid);
    if (e_valid) chk("R8 sample", sample_out, e_sample);
    else         chk("R8 hold", sample_out, e_sample);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cmp_in = 1'b1;
    repeat (3) @(negedge clk);
    zero_model();
    // R1
    chk("R1 drive", drive_out, 0);
    chk("R1 model", model_out, 0);
    chk("R1 sample", sample_out, 0);
    chk("R1 valid", sample_valid, 0);
    rst = 1'b0;
  endtask

  task automatic closed_loop(input longint unsigned vin, input int windows);
    int seen;
    longint diff;
    seen = 0;
    for (int i = 0; i < windows * int'(WIN); i++) begin
      tick(vin > e_model());
      if (sample_valid) begin
        seen++;
        if (seen > 3) begin
          diff = longint'(sample_out) - longint'(vin);
          if (diff < 0) diff = -diff;
          checks++;
          // R9
          if (diff > longint'(FS >> (G + 3))) begin
            errors++;
            $display("FAIL R9 track actual=%0d expected=%0d", sample_out, vin);
          end
        end
      end
    end
  endtask

  initial begin
    #1900000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    bit lvl;
    int run;
    seed = $urandom(32'h5eed_1234);
    zero_model();
    do_reset();

    // R6: first upward step keeps guard bits: model = 160
    tick(1); tick(1); tick(1);   // drive high after the third edge
    tick(1);
    chk("R6 first step", model_out, ((FS >> S1) + (FS >> S2)) >> G);

    // R5: hold high until saturation, then hold low until empty
    for (int i = 0; i < 3000; i++) tick(1);
    chk("R5 high rail", model_out, (1 << W) - 1);
    for (int i = 0; i < 3000; i++) tick(0);
    chk("R5 low rail", model_out, 0);

    // random bits, then random bursts
    for (int i = 0; i < 3 * int'(WIN); i++) tick(1'($urandom));
    run = 0; lvl = 0;
    for (int i = 0; i < 2 * int'(WIN); i++) begin
      if (run == 0) begin
        run = 1 + int'($urandom % 40);
        lvl = 1'($urandom);
      end
      run--;
      tick(lvl);
    end

    // R1 again, mid-run
    do_reset();

    // closed-loop tracking at several input codes
    closed_loop(2048, 5);
    closed_loop(1024, 5);
    closed_loop(3072, 5);
    closed_loop(1536 + longint'($urandom % 1024), 5);

    settle_cnt = 0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule